// File: doc/BRIEF.md
# Programmable Interrupt Routing Crossbar

The block steers a wide set of level-sensitive interrupt request lines onto a narrower set of lines that feed a downstream interrupt controller. Each request line owns one route register. The register holds an enable flag and the index of the output line it drives. Any input may go to any output. When several enabled inputs share an output, that output is their logical OR. The request path is purely combinational: the block has no latching, no edge detection, no priority masking and no acknowledge handling. An output rises and falls together with the inputs that feed it.

Software programs the routes over a simple word-addressed register bus. A write takes effect on the clock edge that samples it, and read data is returned combinationally in the same cycle as the read strobe. A bank of read-only status words shows the live level of every input, 32 inputs to a word.

Word address map, where N is the input count: route registers sit at words 0 to N-1, one per input in input order. Status words follow at words N to N+N/32-1, which are byte offsets 0x200 to 0x20C for 128 inputs. All other words are unmapped.

Top module: `int_route_xbar`

## Requirements
- R1: After reset every route register reads 0 with its enable (bit 31) clear, and every output is low whatever the input levels.
- R2: A write to a route register stores bits [4:0] as the output index and bit 31 as the enable. A read returns those same bits, and bits [30:5] always read 0.
- R3: An input whose route is enabled with an index below the output count drives that output with its own level, in the same cycle and with no register on the path.
- R4: An input whose route enable is clear drives no output.
- R5: An enabled route whose index is at or above the output count (24 to 31 by default) drives no output, yet the index still reads back as written.
- R6: When several enabled inputs select the same output, that output is the OR of their levels.
- R7: Any input can be routed to any output, including the lowest input to output 0 and the highest input to the highest output.
- R8: A read of status word N+k returns the current level of input 32*k+i in bit i. The value is not captured, so it changes as soon as the inputs change.
- R9: Writes to status words or to unmapped words change no route register and no output.
- R10: A read of an unmapped word returns 0.
- R11: The route register of input n sits at word n, so a write to word n affects only input n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IN | Level-sensitive interrupt request inputs |
| irq_o | output | N_OUT | Routed request outputs to the downstream controller |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en_i | input | 1 | Read strobe; read data is valid in the same cycle |
| addr_i | input | ADDR_W | Word address (byte offset divided by 4) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, 0 when no read is active |

## Verification
The bench builds the block with its default parameters: 128 inputs, 24 outputs, 32-bit data and a 10-bit word address. With 24 outputs, the 5-bit index field has eight values (24 to 31) that must route nowhere. The default input count gives four status words, so the bench can check every bit lane of every status word. The 10-bit address leaves unmapped space both directly after the status words and at the top of the map, and the bench uses both for the ignored-write and zero-read cases.

// File: rtl/int_route_xbar_pkg.sv
package int_route_xbar_pkg;
  typedef enum logic [1:0] {
    RGN_ROUTE = 2'd0,
    RGN_STAT  = 2'd1,
    RGN_NONE  = 2'd2
  } xbar_rgn_e;
endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec
  import int_route_xbar_pkg::*;
#(
  parameter int N_IN   = 128,
  parameter int N_STAT = 4,
  parameter int ADDR_W = 10,
  parameter int IN_W   = 7,
  parameter int ST_W   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output xbar_rgn_e         rgn_o,
  output logic [IN_W-1:0]   route_sel_o,
  output logic [ST_W-1:0]   stat_sel_o
);
  logic [ADDR_W-1:0] stat_off;

  assign stat_off    = addr_i - ADDR_W'(N_IN);
  assign route_sel_o = addr_i[IN_W-1:0];
  assign stat_sel_o  = stat_off[ST_W-1:0];

  always_comb begin
    if (addr_i < ADDR_W'(N_IN))               rgn_o = RGN_ROUTE;
    else if (addr_i < ADDR_W'(N_IN + N_STAT)) rgn_o = RGN_STAT;
    else                                      rgn_o = RGN_NONE;
  end
endmodule

// File: rtl/xbar_route_regs.sv
module xbar_route_regs #(
  parameter int N_IN  = 128,
  parameter int IDX_W = 5,
  parameter int IN_W  = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       route_hit_i,
  input  logic [IN_W-1:0]            sel_i,
  input  logic [IDX_W-1:0]           widx_i,
  input  logic                       wen_i,
  output logic [N_IN-1:0]            en_o,
  output logic [N_IN-1:0][IDX_W-1:0] idx_o
);
  logic [N_IN-1:0]            en_q;
  logic [N_IN-1:0][IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      idx_q <= '0;
    end else if (wr_en_i && route_hit_i) begin
      en_q[sel_i]  <= wen_i;
      idx_q[sel_i] <= widx_i;
    end
  end

  assign en_o  = en_q;
  assign idx_o = idx_q;

  AST_ROUTE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && route_hit_i) |=> (idx_q[$past(sel_i)] == $past(widx_i)) &&
                                 (en_q[$past(sel_i)] == $past(wen_i))); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && route_hit_i) |=> $stable(idx_q) && $stable(en_q)); // R9
endmodule

// File: rtl/xbar_route_matrix.sv
module xbar_route_matrix #(
  parameter int N_IN  = 128,
  parameter int N_OUT = 24,
  parameter int IDX_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_IN-1:0]            irq_i,
  input  logic [N_IN-1:0]            en_i,
  input  logic [N_IN-1:0][IDX_W-1:0] idx_i,
  output logic [N_OUT-1:0]           irq_o
);
  // One OR plane per output; out-of-range indices never match any plane.
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    always_comb begin
      irq_o[j] = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (en_i[i] && (idx_i[i] == IDX_W'(j))) irq_o[j] = irq_o[j] | irq_i[i];
      end
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (irq_o == '0)); // R4
  AST_NO_SRC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |-> (irq_o == '0)); // R3
endmodule

// File: rtl/xbar_read_mux.sv
module xbar_read_mux
  import int_route_xbar_pkg::*;
#(
  parameter int N_IN   = 128,
  parameter int N_STAT = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int IN_W   = 7,
  parameter int ST_W   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_en_i,
  input  xbar_rgn_e                  rgn_i,
  input  logic [IN_W-1:0]            route_sel_i,
  input  logic [ST_W-1:0]            stat_sel_i,
  input  logic [N_IN-1:0]            en_i,
  input  logic [N_IN-1:0][IDX_W-1:0] idx_i,
  input  logic [N_IN-1:0]            irq_i,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int PAD_W = N_STAT * DATA_W;

  logic [PAD_W-1:0] irq_pad;

  assign irq_pad = PAD_W'(irq_i);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (rgn_i)
        RGN_ROUTE: begin
          rdata_o[DATA_W-1]  = en_i[route_sel_i];
          rdata_o[IDX_W-1:0] = idx_i[route_sel_i];
        end
        RGN_STAT: rdata_o = irq_pad[int'(stat_sel_i)*DATA_W +: DATA_W];
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rgn_i == RGN_NONE) |-> (rdata_o == '0)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rgn_i == RGN_ROUTE) |-> (rdata_o[DATA_W-2:IDX_W] == '0)); // R2
endmodule

// File: rtl/int_route_xbar.sv
module int_route_xbar
  import int_route_xbar_pkg::*;
#(
  parameter int N_IN   = 128,
  parameter int N_OUT  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   irq_i,
  output logic [N_OUT-1:0]  irq_o,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W  = 5;
  localparam int IN_W   = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int N_STAT = (N_IN + DATA_W - 1) / DATA_W;
  localparam int ST_W   = (N_STAT > 1) ? $clog2(N_STAT) : 1;

  xbar_rgn_e                  rgn;
  logic [IN_W-1:0]            route_sel;
  logic [ST_W-1:0]            stat_sel;
  logic [N_IN-1:0]            route_en;
  logic [N_IN-1:0][IDX_W-1:0] route_idx;
  logic                       unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-2:IDX_W];

  xbar_addr_dec #(
    .N_IN(N_IN), .N_STAT(N_STAT), .ADDR_W(ADDR_W), .IN_W(IN_W), .ST_W(ST_W)
  ) u_dec (
    .addr_i(addr_i), .rgn_o(rgn), .route_sel_o(route_sel), .stat_sel_o(stat_sel)
  );

  xbar_route_regs #(.N_IN(N_IN), .IDX_W(IDX_W), .IN_W(IN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .route_hit_i(rgn == RGN_ROUTE), .sel_i(route_sel),
    .widx_i(wdata_i[IDX_W-1:0]), .wen_i(wdata_i[DATA_W-1]),
    .en_o(route_en), .idx_o(route_idx)
  );

  xbar_route_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .IDX_W(IDX_W)) u_mtx (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .en_i(route_en), .idx_i(route_idx), .irq_o(irq_o)
  );

  xbar_read_mux #(
    .N_IN(N_IN), .N_STAT(N_STAT), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .IN_W(IN_W), .ST_W(ST_W)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rgn_i(rgn),
    .route_sel_i(route_sel), .stat_sel_i(stat_sel), .en_i(route_en),
    .idx_i(route_idx), .irq_i(irq_i), .rdata_o(rdata_o)
  );

  initial begin
    assert (N_OUT <= (1 << IDX_W)) else $error("N_OUT exceeds index field");
    assert (IDX_W < DATA_W - 1) else $error("index field overlaps enable");
  end
endmodule

// File: tb/sim_int_route_xbar.sv
module sim_int_route_xbar;
  localparam int N_IN = 128, N_OUT = 24, DW = 32, AW = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N_IN-1:0] irq = '0;
  logic [N_OUT-1:0] irq_out;
  logic           wr = 1'b0, rd = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_route_xbar #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_o(irq_out),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); rd = 1'b1; addr = AW'(a);
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic chk_out(input string req, input logic [N_OUT-1:0] exp);
    #1 check(req, DW'(irq_out), DW'(exp));
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    irq = '1;
    chk_out("R1 outputs low after reset", '0);
    bus_rd(0, d);   check("R1 route 0 reset", d, '0);
    bus_rd(127, d); check("R1 route 127 reset", d, '0);
    irq = '0;
  endtask

  task automatic t_readback;
    logic [DW-1:0] d;
    bus_wr(5, 32'hFFFF_FFF3);
    bus_rd(5, d);   check("R2 readback masks reserved bits", d, 32'h8000_0013);
    bus_wr(127, 32'h0000_0017);
    bus_rd(127, d); check("R2 readback enable clear", d, 32'h0000_0017);
    bus_rd(6, d);   check("R11 neighbour word untouched", d, '0);
    bus_rd(4, d);   check("R11 lower neighbour untouched", d, '0);
  endtask

  task automatic t_route;
    bus_wr(0, 32'h8000_0000);
    bus_wr(127, 32'h8000_0017);
    irq = '0; irq[127] = 1'b1;
    chk_out("R7 input 127 to output 23", 24'h80_0000);
    irq[0] = 1'b1;
    chk_out("R7 input 0 to output 0", 24'h80_0001);
    irq[127] = 1'b0;
    chk_out("R3 output follows input low", 24'h00_0001);
    irq = '0;
    chk_out("R3 all low", '0);
  endtask

  task automatic t_disabled;
    bus_wr(5, 32'h0000_0013);
    irq = '0; irq[5] = 1'b1;
    chk_out("R4 disabled route drives nothing", '0);
    bus_wr(5, 32'h8000_0013);
    chk_out("R3 re-enabled route drives output 19", 24'h08_0000);
    irq = '0;
  endtask

  task automatic t_bad_idx;
    logic [DW-1:0] d;
    bus_wr(9, 32'h8000_0018);
    irq = '0; irq[9] = 1'b1;
    chk_out("R5 index 24 drives nothing", '0);
    bus_rd(9, d); check("R5 index 24 reads back", d, 32'h8000_0018);
    bus_wr(9, 32'h8000_001F);
    chk_out("R5 index 31 drives nothing", '0);
    irq = '0;
  endtask

  task automatic t_or;
    for (int n = 10; n <= 12; n++) bus_wr(n, 32'h8000_0007);
    irq = '0;
    chk_out("R6 none active", '0);
    irq[11] = 1'b1;
    chk_out("R6 single source", 24'h00_0080);
    irq[11] = 1'b0; irq[10] = 1'b1; irq[12] = 1'b1;
    chk_out("R6 two sources", 24'h00_0080);
    irq[10] = 1'b0;
    chk_out("R6 one source remains", 24'h00_0080);
    irq = '0;
    chk_out("R6 all dropped", '0);
  endtask

  task automatic t_status;
    logic [DW-1:0] d;
    logic [DW-1:0] pat [4] = '{32'h5A5A_A5A5, 32'h89AB_CDEF, 32'h0123_4567, 32'hDEAD_BEEF};
    irq = {pat[3], pat[2], pat[1], pat[0]};
    for (int k = 0; k < 4; k++) begin
      bus_rd(128 + k, d); check($sformatf("R8 status word %0d", k), d, pat[k]);
    end
    irq = ~irq;
    bus_rd(130, d); check("R8 status is live", d, ~pat[2]);
    irq = '0;
    bus_rd(131, d); check("R8 status cleared", d, '0);
  endtask

  task automatic t_ignored;
    logic [DW-1:0] d;
    bus_wr(128, 32'hFFFF_FFFF);
    bus_wr(131, 32'h8000_0003);
    bus_wr(132, 32'h8000_0004);
    bus_wr(1023, 32'hFFFF_FFFF);
    bus_rd(0, d);   check("R9 route 0 unchanged", d, 32'h8000_0000);
    bus_rd(100, d); check("R9 route 100 unchanged", d, '0);
    bus_rd(3, d);   check("R9 route 3 unchanged", d, '0);
    irq = '0; irq[100] = 1'b1; irq[3] = 1'b1; irq[4] = 1'b1;
    chk_out("R9 outputs unchanged", '0);
    bus_rd(128, d); check("R9 status still live", d, 32'h0000_0018);
    irq = '0;
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] d;
    bus_rd(132, d);  check("R10 word after status", d, '0);
    bus_rd(500, d);  check("R10 mid gap", d, '0);
    bus_rd(1023, d); check("R10 top word", d, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_readback;
    t_route;
    t_disabled;
    t_bad_idx;
    t_or;
    t_status;
    t_ignored;
    t_unmapped;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule